// File: doc/BRIEF.md
# Two-Stage Pipelined 64-bit Adder

This block adds two 64-bit unsigned operands and returns a 65-bit sum. The carry chain is broken in the middle. In the first stage the lower 32-bit halves are added and the 33-bit result is registered, with its carry-out as the top bit. The upper halves are registered alongside it so that they stay aligned. In the second stage the upper halves are added together with that registered carry. The registered partial sum supplies the low 32 bits of the result unchanged. No single 64-bit carry path exists, so the block can run at a higher clock rate than a flat adder.

Each operand pair has a one-bit valid flag that moves through the pipeline with the data, so the caller can tell which output cycles carry real results. The block accepts a new pair every clock. It has no ready signal and cannot stall: the caller must take each result in the cycle it appears.

Top module: `wide_pipe_adder`

## Requirements
- R1: `sum_out` equals the full 65-bit unsigned sum of `opnd_a` and `opnd_b` as sampled at the rising edge two clocks earlier.
- R2: `out_valid` is high in exactly those cycles where `in_valid` was high two rising edges earlier. Back-to-back pairs produce back-to-back results at one per clock.
- R3: A carry out of bit 31 of the lower half reaches bit 32 of the result. For example, 0x00000000_FFFFFFFF + 1 gives 0x0_00000001_00000000.
- R4: Bit 64 of `sum_out` is the overall carry-out. 0xFFFF_FFFF_FFFF_FFFF + 0xFFFF_FFFF_FFFF_FFFF gives 0x1_FFFF_FFFF_FFFF_FFFE.
- R5: An all-ones operand plus one gives exactly bit 64 set and all other bits clear. The carry ripples across both halves and the stage boundary.
- R6: While `rst` is high at a rising edge, every pipeline register clears. After that edge `out_valid` is 0 and `sum_out` is 0.
- R7: The data path advances on every clock whatever the value of `in_valid`. A pair presented with `in_valid` low still appears as its sum on `sum_out` two clocks later, with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand pair as a real request |
| opnd_a | input | 64 | First addend |
| opnd_b | input | 64 | Second addend |
| out_valid | output | 1 | Marks `sum_out` as the result of a valid pair |
| sum_out | output | 65 | Sum; bit 64 is the carry-out |

## Verification
The bench aims at the carry that crosses the stage boundary. A design that drops or misroutes the registered carry gets 0xFFFFFFFF + 1 wrong by exactly 2^32. A design that reads that carry one cycle late corrupts the next vector in a back-to-back stream instead. Maximum plus maximum and all-ones plus one expose a lost bit 64 or a truncated upper adder. A single isolated valid pulse, a sum taken with valid low, and a reset in the middle of a stream show a valid flag with the wrong latency, data gated by the valid flag, or registers that survive reset.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  localparam int unsigned OP_W = 64;
  localparam int unsigned CUT  = 32;
  localparam int unsigned UP_W = OP_W - CUT;
endpackage

// File: rtl/wadd_lo_stage.sv
module wadd_lo_stage #(
  parameter int unsigned LO_W = wadd_pkg::CUT,
  parameter int unsigned HI_W = wadd_pkg::UP_W,
  localparam int unsigned W   = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [LO_W:0]   lo_q,
  output logic [HI_W-1:0] a_hi_q,
  output logic [HI_W-1:0] b_hi_q
);
  logic [LO_W:0] lo_next;
  assign lo_next = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      a_hi_q <= '0;
      b_hi_q <= '0;
    end else begin
      lo_q   <= lo_next;
      a_hi_q <= a[W-1:LO_W];
      b_hi_q <= b[W-1:LO_W];
    end
  end

  // R3
  lo_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> lo_q[LO_W] == ($past(a[LO_W-1:0]) > ~$past(b[LO_W-1:0])));
endmodule

// File: rtl/wadd_hi_stage.sv
module wadd_hi_stage #(
  parameter int unsigned LO_W = wadd_pkg::CUT,
  parameter int unsigned HI_W = wadd_pkg::UP_W,
  localparam int unsigned W   = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LO_W:0]   lo_q,
  input  logic [HI_W-1:0] a_hi_q,
  input  logic [HI_W-1:0] b_hi_q,
  output logic [W:0]      sum_q
);
  logic [HI_W:0] hi_next;
  assign hi_next = {1'b0, a_hi_q} + {1'b0, b_hi_q} + {{HI_W{1'b0}}, lo_q[LO_W]};

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= {hi_next, lo_q[LO_W-1:0]};
  end

  // R3
  carry_in_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lo_q[LO_W]) && $past(a_hi_q) == {HI_W{1'b1}})
      |-> sum_q[W:LO_W] == {1'b1, $past(b_hi_q)});
endmodule

// File: rtl/wadd_valid_pipe.sv
module wadd_valid_pipe (
  input  logic clk,
  input  logic rst,
  input  logic v_in,
  output logic v_out
);
  logic v_mid;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_mid <= 1'b0;
      v_out <= 1'b0;
      age   <= '0;
    end else begin
      v_mid <= v_in;
      v_out <= v_mid;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> v_out == $past(v_in, 2));

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !v_out);
endmodule

// File: rtl/wide_pipe_adder.sv
module wide_pipe_adder #(
  parameter int unsigned OP_W = wadd_pkg::OP_W,
  parameter int unsigned CUT  = wadd_pkg::CUT,
  localparam int unsigned UP_W = OP_W - CUT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [OP_W-1:0] opnd_a,
  input  logic [OP_W-1:0] opnd_b,
  output logic          out_valid,
  output logic [OP_W:0] sum_out
);
  logic [CUT:0]    lo_q;
  logic [UP_W-1:0] a_hi_q;
  logic [UP_W-1:0] b_hi_q;

  wadd_lo_stage #(.LO_W(CUT), .HI_W(UP_W)) u_lo (
    .clk(clk), .rst(rst), .a(opnd_a), .b(opnd_b),
    .lo_q(lo_q), .a_hi_q(a_hi_q), .b_hi_q(b_hi_q)
  );

  wadd_hi_stage #(.LO_W(CUT), .HI_W(UP_W)) u_hi (
    .clk(clk), .rst(rst), .lo_q(lo_q), .a_hi_q(a_hi_q), .b_hi_q(b_hi_q),
    .sum_q(sum_out)
  );

  wadd_valid_pipe u_vld (
    .clk(clk), .rst(rst), .v_in(in_valid), .v_out(out_valid)
  );

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R1
  full_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> sum_out == $past({1'b0, opnd_a} + {1'b0, opnd_b}, 2));

  // R6
  sum_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sum_out == '0);
endmodule

// File: tb/wide_pipe_adder_tb.sv
module wide_pipe_adder_tb;
  localparam int N = 8;
  localparam logic [63:0] VA [N] = '{
    64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000, 64'h7FFF_FFFF_8000_0000,
    64'hFFFF_FFFF_0000_0000, 64'h0000_0001_FFFF_FFFF};
  localparam logic [63:0] VB [N] = '{
    64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001,
    64'h0FED_CBA9_8765_4321, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000,
    64'h0000_0001_0000_0000, 64'hFFFF_FFFE_0000_0001};
  localparam string VR [N] = '{"R3", "R4", "R5", "R1", "R1", "R3", "R4", "R3"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic out_valid;
  logic [64:0] sum_out;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wide_pipe_adder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .out_valid(out_valid), .sum_out(sum_out)
  );

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [64:0] ref_sum(input logic [63:0] a, input logic [63:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R6: held in reset
    chk("R6", {64'b0, out_valid}, 65'd0);
    chk("R6", sum_out, 65'd0);
    rst = 1'b0;
    // Back-to-back stream: R1/R2 plus corners
    for (int i = 0; i < N + 2; i++) begin
      if (i >= 2) begin
        chk(VR[i-2], sum_out, ref_sum(VA[i-2], VB[i-2]));
        chk("R2", {64'b0, out_valid}, 65'd1);
      end
      if (i < N) begin
        in_valid = 1'b1; opnd_a = VA[i]; opnd_b = VB[i];
      end else begin
        in_valid = 1'b0; opnd_a = '0; opnd_b = '0;
      end
      @(negedge clk);
    end
    chk("R2", {64'b0, out_valid}, 65'd0);
    // R2: isolated pulse
    in_valid = 1'b1; opnd_a = 64'd5; opnd_b = 64'd7;
    @(negedge clk);
    in_valid = 1'b0; opnd_a = '0; opnd_b = '0;
    chk("R2", {64'b0, out_valid}, 65'd0);
    @(negedge clk);
    chk("R2", {64'b0, out_valid}, 65'd1);
    chk("R1", sum_out, 65'd12);
    @(negedge clk);
    chk("R2", {64'b0, out_valid}, 65'd0);
    // R7: data flows with valid low
    opnd_a = 64'hDEAD_0000_FFFF_FFFF; opnd_b = 64'h0000_BEEF_0000_0003;
    @(negedge clk);
    opnd_a = '0; opnd_b = '0;
    @(negedge clk);
    chk("R7", sum_out, ref_sum(64'hDEAD_0000_FFFF_FFFF, 64'h0000_BEEF_0000_0003));
    chk("R7", {64'b0, out_valid}, 65'd0);
    // R6: reset mid-stream
    in_valid = 1'b1; opnd_a = '1; opnd_b = '1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R6", {64'b0, out_valid}, 65'd0);
    chk("R6", sum_out, 65'd0);
    in_valid = 1'b0; opnd_a = '0; opnd_b = '0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6", {64'b0, out_valid}, 65'd0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule